// File: doc/BRIEF.md
# Track Power and Fault Supervisor

This block decides whether the layout track is powered and whether the point-capacitor discharge unit is armed, and it drives a single user fault lamp. It takes one-cycle ON and OFF command strobes from the host command decoder, a level short-circuit detect from the track booster, and watchdog reload requests that carry a 7-bit period count. It returns one-cycle event strobes that the reply path turns into host messages: a fault report, a retry-permitted report and a watchdog-expired report.

After a short, the track drops at once. The capacitor unit stays armed until a fixed 500 ms minimum off time ends. During that time the lamp flashes fast, and at its end the retry-permitted event is raised. Power never returns on its own: only a host ON command re-enables the track. When the host stops reloading the watchdog, the track drops, the capacitor unit stays armed and the lamp lights steadily. All timing comes from a millisecond prescaler that is derived from the clock frequency parameter.

Top module: `trackpwr_supervisor`

## Requirements
- R1: During and after a synchronous reset, with no command given, `track_en`, `cdu_en` and all three event strobes are low.
- R2: In the powered state, `track_en` and `cdu_en` are both high and `fault_led` is low. An ON strobe from the off or watchdog-expired state takes effect at the same clock edge that samples it.
- R3: An OFF strobe drops `track_en` and `cdu_en` at the edge that samples it. In the off state `fault_led` flashes at 1 Hz with a 50 % duty cycle.
- R4: A high `short_det` sampled while powered gives a one-cycle `ev_fault`, drops `track_en` at the same edge and leaves `cdu_en` high. `short_det` has no effect in the off state.
- R5: The post-fault window lasts exactly 500 ms, which is 500 × CLK_HZ/1000 cycles after the fault edge. During the window `fault_led` flashes at 4 Hz with a 50 % duty cycle. At the end of the window `ev_retriable` pulses and `cdu_en` drops.
- R6: Removing the short never re-enables the track. `track_en` rises only on an ON command.
- R7: A reload in the powered state with count M > 0 restarts the watchdog with a period of M × 16 ms. A later reload restarts the count. M = 0 disarms the watchdog. On expiry, `ev_wtimeout` pulses, `track_en` drops, `cdu_en` stays high and `fault_led` is lit steadily.
- R8: An ON or OFF received during the post-fault window is held, and the last one received wins. The held command is applied at the window end, on the edge of `ev_retriable`: ON returns to powered and OFF (or none) goes to off. A command sampled on the expiry edge itself counts.
- R9: In the powered state, OFF has priority over a short sampled at the same edge: the block goes to off and no `ev_fault` is raised.
- R10: At most one event strobe is high in any cycle, and each strobe is exactly one cycle wide.
- R11: Watchdog reloads received while not powered are ignored. A later ON starts with the watchdog disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 1 | One-cycle ON command strobe |
| cmd_off | input | 1 | One-cycle OFF command strobe |
| short_det | input | 1 | Track short-circuit detect level |
| wd_load | input | 1 | Watchdog reload strobe |
| wd_m | input | 7 | Watchdog period in 16 ms units, 0 disarms |
| track_en | output | 1 | Track power enable |
| cdu_en | output | 1 | Point-capacitor unit enable |
| fault_led | output | 1 | User fault lamp |
| ev_fault | output | 1 | Short detected event |
| ev_retriable | output | 1 | Post-fault window ended event |
| ev_wtimeout | output | 1 | Watchdog expired event |

## Verification
Every output is a flop that is loaded from the next-state decode. A command or short sampled at edge E is therefore visible just after E, and the bench reads it at the following falling edge. A timed result is due exactly T × CLK_HZ/1000 edges after the sampling edge, where T is 500 for the post-fault window and M × 16 for the watchdog. The driver computes that edge number from a bench cycle counter and queues it. The monitor compares every event strobe against the head of the queue by kind and by cycle, so an early, late, missing or extra event is reported. Lamp rates are checked by counting lit samples over a whole number of flash periods.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_HOLD = 2'd2,
    ST_WDT  = 2'd3
  } trk_state_e;
endpackage

// File: rtl/trk_ms_timer.sv
// One-shot millisecond timer: expires exactly target*CYC_PER_MS cycles after start.
module trk_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int TGT_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [TGT_W-1:0] target,
  output logic             expire
);
  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic             run;
  logic [PRE_W-1:0] pre;
  logic [TGT_W-1:0] ms;
  logic [TGT_W-1:0] tgt;

  assign expire = run && (pre == PRE_LAST) && (ms == tgt - TGT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      pre <= '0;
      ms  <= '0;
      tgt <= '0;
    end else if (start) begin
      run <= 1'b1;
      pre <= '0;
      ms  <= '0;
      tgt <= target;
    end else if (stop || expire) begin
      run <= 1'b0;
    end else if (run) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        ms  <= ms + TGT_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/trk_flash_gen.sv
// Free-running lamp pattern source: slow and fast 50 % square waves.
module trk_flash_gen #(
  parameter int CYC_PER_MS = 50000,
  parameter int SLOW_MS    = 1000,
  parameter int FAST_MS    = 250
) (
  input  logic clk,
  input  logic rst,
  output logic slow,
  output logic fast
);
  localparam int PRE_W  = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int SLOW_W = $clog2(SLOW_MS);
  localparam int FAST_W = $clog2(FAST_MS);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0]  pre;
  logic [SLOW_W-1:0] slow_cnt;
  logic [FAST_W-1:0] fast_cnt;
  logic              tick;

  assign tick = (pre == PRE_LAST);
  assign slow = (slow_cnt < SLOW_W'(SLOW_MS / 2));
  assign fast = (fast_cnt < FAST_W'(FAST_MS / 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      slow_cnt <= '0;
      fast_cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + PRE_W'(1);
      if (tick) begin
        slow_cnt <= (slow_cnt == SLOW_W'(SLOW_MS - 1)) ? '0 : slow_cnt + SLOW_W'(1);
        fast_cnt <= (fast_cnt == FAST_W'(FAST_MS - 1)) ? '0 : fast_cnt + FAST_W'(1);
      end
    end
  end
endmodule

// File: rtl/trackpwr_supervisor.sv
module trackpwr_supervisor #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int OFF_MS     = 500,
  parameter int WD_UNIT_MS = 16,
  parameter int WDM_W      = 7,
  parameter int SLOW_MS    = 1000,
  parameter int FAST_MS    = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_on,
  input  logic             cmd_off,
  input  logic             short_det,
  input  logic             wd_load,
  input  logic [WDM_W-1:0] wd_m,
  output logic             track_en,
  output logic             cdu_en,
  output logic             fault_led,
  output logic             ev_fault,
  output logic             ev_retriable,
  output logic             ev_wtimeout
);
  import trk_pkg::*;

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int WIN_W      = $clog2(OFF_MS + 1);
  localparam int WDT_W      = WDM_W + $clog2(WD_UNIT_MS) + 1;

  trk_state_e st, st_nxt;
  logic pend_on, pend_nxt;
  logic win_start, win_expire;
  logic wd_start, wd_stop, wd_expire;
  logic slow, fast;
  logic f_nxt, r_nxt, w_nxt;
  logic wd_arm_req;

  assign wd_arm_req = wd_load && (wd_m != '0);

  always_comb begin
    st_nxt   = st;
    f_nxt    = 1'b0;
    r_nxt    = 1'b0;
    w_nxt    = 1'b0;
    pend_nxt = pend_on;
    unique case (st)
      ST_OFF: if (!cmd_off && cmd_on) st_nxt = ST_ON;
      ST_ON: begin
        if (cmd_off) begin
          st_nxt = ST_OFF;
        end else if (short_det) begin
          st_nxt   = ST_HOLD;
          f_nxt    = 1'b1;
          pend_nxt = 1'b0;
        end else if (wd_expire && !wd_arm_req) begin
          st_nxt = ST_WDT;
          w_nxt  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cmd_off)     pend_nxt = 1'b0;
        else if (cmd_on) pend_nxt = 1'b1;
        if (win_expire) begin
          st_nxt = pend_nxt ? ST_ON : ST_OFF;
          r_nxt  = 1'b1;
        end
      end
      ST_WDT: begin
        if (cmd_off)     st_nxt = ST_OFF;
        else if (cmd_on) st_nxt = ST_ON;
      end
      default: st_nxt = ST_OFF;
    endcase
  end

  assign win_start = (st == ST_ON) && (st_nxt == ST_HOLD);
  assign wd_start  = (st == ST_ON) && (st_nxt == ST_ON) && wd_arm_req;
  assign wd_stop   = (st_nxt != ST_ON) || ((st == ST_ON) && wd_load && (wd_m == '0));

  trk_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .TGT_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .start(win_start), .stop(1'b0),
    .target(WIN_W'(OFF_MS)), .expire(win_expire)
  );

  trk_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .TGT_W(WDT_W)) u_wdog (
    .clk(clk), .rst(rst), .start(wd_start), .stop(wd_stop),
    .target(WDT_W'(wd_m) * WDT_W'(WD_UNIT_MS)), .expire(wd_expire)
  );

  trk_flash_gen #(.CYC_PER_MS(CYC_PER_MS), .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS)) u_flash (
    .clk(clk), .rst(rst), .slow(slow), .fast(fast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_OFF;
      pend_on      <= 1'b0;
      track_en     <= 1'b0;
      cdu_en       <= 1'b0;
      fault_led    <= 1'b0;
      ev_fault     <= 1'b0;
      ev_retriable <= 1'b0;
      ev_wtimeout  <= 1'b0;
    end else begin
      st           <= st_nxt;
      pend_on      <= pend_nxt;
      track_en     <= (st_nxt == ST_ON);
      cdu_en       <= (st_nxt != ST_OFF);
      ev_fault     <= f_nxt;
      ev_retriable <= r_nxt;
      ev_wtimeout  <= w_nxt;
      unique case (st_nxt)
        ST_OFF:  fault_led <= slow;
        ST_HOLD: fault_led <= fast;
        ST_WDT:  fault_led <= 1'b1;
        default: fault_led <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/trk_supervisor_chk.sv
module trk_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic cmd_on,
  input logic track_en,
  input logic cdu_en,
  input logic fault_led,
  input logic ev_fault,
  input logic ev_retriable,
  input logic ev_wtimeout
);
  a_r10_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_fault, ev_retriable, ev_wtimeout}));

  a_r10_fault_width: assert property (@(posedge clk) disable iff (rst)
    ev_fault |=> !ev_fault);

  a_r10_retry_width: assert property (@(posedge clk) disable iff (rst)
    ev_retriable |=> !ev_retriable);

  a_r10_wto_width: assert property (@(posedge clk) disable iff (rst)
    ev_wtimeout |=> !ev_wtimeout);

  a_r4_fault_outputs: assert property (@(posedge clk) disable iff (rst)
    ev_fault |-> (!track_en && cdu_en));

  a_r5_retry_cdu_off_or_on: assert property (@(posedge clk) disable iff (rst)
    ev_retriable |-> (cdu_en == track_en));

  a_r7_wto_outputs: assert property (@(posedge clk) disable iff (rst)
    ev_wtimeout |-> (!track_en && cdu_en && fault_led));

  a_r2_track_needs_cdu: assert property (@(posedge clk) disable iff (rst)
    track_en |-> cdu_en);

  a_r6_track_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(track_en) |-> ($past(cmd_on) || ev_retriable));
endmodule

bind trackpwr_supervisor trk_supervisor_chk u_chk (.*);

// File: tb/trackpwr_supervisor_test.sv
module trackpwr_supervisor_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_HZ = 20000;
  localparam int C      = CLK_HZ / 1000;
  localparam int WIN    = 500 * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_on = 1'b0, cmd_off = 1'b0, short_det = 1'b0, wd_load = 1'b0;
  logic [6:0] wd_m = '0;
  logic track_en, cdu_en, fault_led, ev_fault, ev_retriable, ev_wtimeout;

  trackpwr_supervisor #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .short_det(short_det), .wd_load(wd_load), .wd_m(wd_m),
    .track_en(track_en), .cdu_en(cdu_en), .fault_led(fault_led),
    .ev_fault(ev_fault), .ev_retriable(ev_retriable), .ev_wtimeout(ev_wtimeout)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_kind[$];
  int exp_cyc[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // kind: 1 fault, 2 retriable, 3 watchdog timeout
  task automatic expect_ev(input int kind, input int at);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
  endtask

  // monitor: compares every event strobe with the scoreboard head
  always @(negedge clk) begin
    if (!rst && (ev_fault || ev_retriable || ev_wtimeout)) begin
      int k;
      chk($countones({ev_fault, ev_retriable, ev_wtimeout}) == 1, "R10 one strobe",
          $countones({ev_fault, ev_retriable, ev_wtimeout}), 1);
      k = ev_fault ? 1 : (ev_retriable ? 2 : 3);
      if (exp_kind.size() == 0) begin
        chk(1'b0, "R4/R9/R10 unexpected event", k, 0);
      end else begin
        int ek, ec;
        ek = exp_kind.pop_front();
        ec = exp_cyc.pop_front();
        chk(k == ek, "R5/R7 event kind", k, ek);
        chk(cyc == ec, "R5/R7 event cycle", cyc, ec);
      end
    end
  end

  task automatic pulse_on(output int e);
    @(negedge clk); cmd_on = 1'b1; e = cyc + 1;
    @(negedge clk); cmd_on = 1'b0;
  endtask

  task automatic pulse_load(input logic [6:0] m, output int e);
    @(negedge clk); wd_load = 1'b1; wd_m = m; e = cyc + 1;
    @(negedge clk); wd_load = 1'b0;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int e, lit;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!track_en && !cdu_en, "R1 outputs in reset", {track_en, cdu_en}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!track_en && !cdu_en && !ev_fault && !ev_retriable && !ev_wtimeout,
        "R1 idle after reset", {track_en, cdu_en}, 0);

    // R2: power on
    pulse_on(e);
    chk(track_en && cdu_en && !fault_led, "R2 powered outputs",
        {track_en, cdu_en, fault_led}, 3'b110);

    // R4/R5/R6/R8: short, window with ON then OFF held (last wins: OFF)
    @(negedge clk); short_det = 1'b1; e = cyc + 1;
    expect_ev(1, e);
    expect_ev(2, e + WIN);
    lit = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      lit += fault_led;
      if (i == 0) chk(!track_en && cdu_en, "R4 track drops, cdu kept", {track_en, cdu_en}, 1);
      if (i == 100) short_det = 1'b0;
      if (i == 3000) cmd_on = 1'b1;
      if (i == 3001) cmd_on = 1'b0;
      if (i == 5000) chk(!track_en, "R6 no re-enable in window", track_en, 0);
      if (i == 6000) cmd_off = 1'b1;
      if (i == 6001) cmd_off = 1'b0;
    end
    chk(lit == WIN / 2, "R5 fast flash duty", lit, WIN / 2);
    @(negedge clk);
    chk(!track_en && !cdu_en, "R5/R8 window end held OFF", {track_en, cdu_en}, 0);
    repeat (50) @(negedge clk);
    chk(!track_en, "R6 short cleared stays off", track_en, 0);

    // R3 slow flash in off, R4 short ignored, R11 reload ignored
    lit = 0;
    for (int i = 0; i < 1000 * C; i++) begin
      @(negedge clk);
      lit += fault_led;
      if (i == 10) short_det = 1'b1;
      if (i == 500) begin wd_load = 1'b1; wd_m = 7'd1; end
      if (i == 501) wd_load = 1'b0;
      if (i == 900 * C) short_det = 1'b0;
    end
    chk(lit == 500 * C, "R3 slow flash duty", lit, 500 * C);
    chk(!track_en && !cdu_en, "R4 short ignored when off", {track_en, cdu_en}, 0);
    pulse_on(e);
    repeat (16 * C + 60) @(negedge clk);
    chk(track_en, "R11 off-state reload ignored", track_en, 1);

    // R7: arm M=2, reload M=1 before expiry
    pulse_load(7'd2, e);
    repeat (300) @(negedge clk);
    pulse_load(7'd1, e);
    expect_ev(3, e + 16 * C);
    wait_cyc(e + 16 * C - 1);
    chk(track_en, "R7 reload restarts count", track_en, 1);
    @(negedge clk);
    chk(!track_en && cdu_en && fault_led, "R7 timeout outputs",
        {track_en, cdu_en, fault_led}, 3'b011);
    repeat (40) @(negedge clk);
    chk(fault_led, "R7 lamp steady", fault_led, 1);

    // R2 recover from watchdog state, R7 M=0 disarms
    pulse_on(e);
    chk(track_en && cdu_en && !fault_led, "R2 on from watchdog state",
        {track_en, cdu_en, fault_led}, 3'b110);
    pulse_load(7'd1, e);
    pulse_load(7'd0, e);
    repeat (16 * C + 100) @(negedge clk);
    chk(track_en, "R7 M=0 disarms", track_en, 1);

    // R9: OFF and short at the same edge
    @(negedge clk); cmd_off = 1'b1; short_det = 1'b1;
    @(negedge clk); cmd_off = 1'b0; short_det = 1'b0;
    chk(!track_en && !cdu_en, "R9 off beats short", {track_en, cdu_en}, 0);

    // R8: ON held, sampled on the expiry edge itself
    pulse_on(e);
    @(negedge clk); short_det = 1'b1; e = cyc + 1;
    expect_ev(1, e);
    expect_ev(2, e + WIN);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (i == 50) short_det = 1'b0;
      if (i == WIN - 1) cmd_on = 1'b1;
    end
    @(negedge clk); cmd_on = 1'b0;
    chk(track_en && cdu_en && !fault_led, "R8 held ON applied at window end",
        {track_en, cdu_en, fault_led}, 3'b110);

    repeat (10) @(negedge clk);
    chk(exp_kind.size() == 0, "R5/R7 all expected events seen", exp_kind.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule